// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down for a small 8-bit processor core. Instruction decode raises a one-cycle sleep request. The controller then gates the core clock and pulses a watchdog clear, and it updates two status bits. One bit records power-down and the other records time-out. While asleep it watches two kinds of wake source: interrupt sources whose individual enable is set, and a watchdog time-out when the watchdog is enabled. The core's global interrupt enable plays no part in waking.

After a wake, the block models the oscillator start-up delay with a cycle counter. It then gives the core a one-cycle resume pulse. A qualifier tells the core whether to continue in line or to branch to the interrupt vector after the next instruction. A sleep request that arrives while an enabled interrupt is already pending skips the sleep and the start-up delay. A watchdog time-out during normal running produces a reset pulse for the core only. An external reset returns the block to the running state from any state.

Top module: `swc_ctrl`

## Requirements
- R1: After power-on reset (rst_ni low) the core clock is enabled, pd_o=1, to_o=1, and resume_o, vector_o, wdt_clr_o and wdt_rst_o are 0.
- R2: A sleep request while running, with no pending enabled interrupt and no enabled watchdog time-out, does three things in the next cycle: it gates clk_en_o to 0, clears pd_o and sets to_o, and pulses wdt_clr_o high for one cycle.
- R3: While asleep, an interrupt source with both its enable bit and its flag bit set (bit i of int_en_i and int_flag_i) wakes the block whatever gie_i holds. A flag whose enable bit is 0 does not wake it.
- R4: While asleep, a watchdog time-out wakes the block only when wdt_en_i=1. Such a wake clears to_o. Every wake pulses wdt_clr_o for one cycle.
- R5: After a wake from sleep, clk_en_o stays 0 for exactly STARTUP_CYCLES cycles, and resume_o follows in the next cycle.
- R6: resume_o is high for one cycle with clk_en_o=1. In that cycle, vector_o=1 exactly when the wake was caused by an enabled interrupt and gie_i=1. A wake caused only by the watchdog gives vector_o=0.
- R7: A sleep request made while an enabled interrupt is pending gives resume_o in the next cycle, with no start-up delay. It still clears pd_o, sets to_o and pulses wdt_clr_o.
- R8: An enabled watchdog time-out while running pulses wdt_rst_o for one cycle and sets to_o=0 and pd_o=1. A disabled one has no effect. The block has no output that drives the external reset pin.
- R9: ext_rst_i in any state returns the block to running in the next cycle. It abandons any wake in progress, so no resume_o follows. It sets to_o=1 and keeps pd_o.
- R10: While running, interrupt flags and enables have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_i | input | 1 | External reset request, synchronous |
| sleep_req_i | input | 1 | Sleep request from instruction decode |
| gie_i | input | 1 | Core global interrupt enable |
| int_en_i | input | NUM_IRQ | Per-source interrupt enables |
| int_flag_i | input | NUM_IRQ | Per-source interrupt flags |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | Watchdog time-out event |
| clk_en_o | output | 1 | Core clock enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| wdt_rst_o | output | 1 | Core reset pulse from watchdog time-out |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| resume_o | output | 1 | One-cycle resume pulse |
| vector_o | output | 1 | Branch to interrupt vector after next instruction |

## Verification
Every result except vector_o is registered, so it appears in the cycle after the clock edge that samples the stimulus. vector_o is combinational on gie_i during the resume cycle. The start-up interval adds exactly STARTUP_CYCLES gated cycles between the wake edge and resume. The bench drives inputs shortly after each rising edge and updates a behavioural model on the same edge. At each falling edge it compares every output against that model, so each result is checked in the exact cycle it is due.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_OSC    = 2'd2,
    ST_RESUME = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] int_en_i,
  input  logic [NUM_IRQ-1:0] int_flag_i,
  input  logic               wdt_en_i,
  input  logic               wdt_timeout_i,
  output logic               int_pend_o,
  output logic               wdt_hit_o
);
  logic [NUM_IRQ-1:0] armed;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign armed[i] = int_en_i[i] & int_flag_i[i];
  end

  assign int_pend_o = |armed;
  assign wdt_hit_o  = wdt_en_i & wdt_timeout_i;
endmodule

// File: rtl/swc_startup_timer.sv
module swc_startup_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/swc_status.sv
module swc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_i,
  input  logic sleep_enter_i,
  input  logic wdt_wake_i,
  input  logic wdt_reset_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (ext_rst_i) begin
      to_o <= 1'b1;               // pd kept: tells reset-in-sleep apart
    end else if (wdt_reset_i) begin
      pd_o <= 1'b1;
      to_o <= 1'b0;
    end else if (sleep_enter_i) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end else if (wdt_wake_i) begin
      to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int NUM_IRQ        = 4,
  parameter int STARTUP_CYCLES = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_i,
  input  logic               sleep_req_i,
  input  logic               gie_i,
  input  logic [NUM_IRQ-1:0] int_en_i,
  input  logic [NUM_IRQ-1:0] int_flag_i,
  input  logic               wdt_en_i,
  input  logic               wdt_timeout_i,
  output logic               clk_en_o,
  output logic               wdt_clr_o,
  output logic               wdt_rst_o,
  output logic               pd_o,
  output logic               to_o,
  output logic               resume_o,
  output logic               vector_o
);
  swc_state_e state_q, state_d;
  logic int_pend, wdt_hit, osc_done;
  logic enter_sleep, wake, wdt_reset;
  logic int_cause_q, wdt_clr_q, wdt_rst_q;

  swc_wake_detect #(.NUM_IRQ(NUM_IRQ)) i_wake (
    .int_en_i     (int_en_i),
    .int_flag_i   (int_flag_i),
    .wdt_en_i     (wdt_en_i),
    .wdt_timeout_i(wdt_timeout_i),
    .int_pend_o   (int_pend),
    .wdt_hit_o    (wdt_hit)
  );

  swc_startup_timer #(.CYCLES(STARTUP_CYCLES)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_OSC && !ext_rst_i),
    .done_o(osc_done)
  );

  assign wdt_reset   = !ext_rst_i && state_q == ST_RUN && wdt_hit;
  assign enter_sleep = !ext_rst_i && state_q == ST_RUN && !wdt_hit && sleep_req_i;
  assign wake        = !ext_rst_i && state_q == ST_SLEEP && (int_pend || wdt_hit);

  swc_status i_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_rst_i    (ext_rst_i),
    .sleep_enter_i(enter_sleep),
    .wdt_wake_i   (wake && wdt_hit),
    .wdt_reset_i  (wdt_reset),
    .pd_o         (pd_o),
    .to_o         (to_o)
  );

  always_comb begin
    state_d = state_q;
    if (ext_rst_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:    if (enter_sleep) state_d = int_pend ? ST_RESUME : ST_SLEEP;
        ST_SLEEP:  if (wake) state_d = ST_OSC;
        ST_OSC:    if (osc_done) state_d = ST_RESUME;
        ST_RESUME: state_d = ST_RUN;
        default:   state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      int_cause_q <= 1'b0;
      wdt_clr_q   <= 1'b0;
      wdt_rst_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      wdt_clr_q <= enter_sleep || wake;
      wdt_rst_q <= wdt_reset;
      if (ext_rst_i || state_q == ST_RESUME) int_cause_q <= 1'b0;
      else if (enter_sleep || wake)          int_cause_q <= int_pend;
    end
  end

  assign clk_en_o  = (state_q == ST_RUN) || (state_q == ST_RESUME);
  assign resume_o  = (state_q == ST_RESUME);
  assign vector_o  = resume_o && int_cause_q && gie_i;
  assign wdt_clr_o = wdt_clr_q;
  assign wdt_rst_o = wdt_rst_q;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int NUM_IRQ = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ext_rst_i,
  input logic               sleep_req_i,
  input logic               gie_i,
  input logic [NUM_IRQ-1:0] int_en_i,
  input logic [NUM_IRQ-1:0] int_flag_i,
  input logic               wdt_en_i,
  input logic               wdt_timeout_i,
  input logic               clk_en_o,
  input logic               wdt_clr_o,
  input logic               wdt_rst_o,
  input logic               pd_o,
  input logic               to_o,
  input logic               resume_o,
  input logic               vector_o
);
  logic running, pend, wdt_ev;
  assign running = clk_en_o && !resume_o;
  assign pend    = |(int_en_i & int_flag_i);
  assign wdt_ev  = wdt_en_i && wdt_timeout_i;

  assert_sleep_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && sleep_req_i && !ext_rst_i && !wdt_ev && !pend)
      |=> (!clk_en_o && !pd_o && to_o && wdt_clr_o));

  assert_immediate_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && sleep_req_i && !ext_rst_i && !wdt_ev && pend)
      |=> (resume_o && !pd_o && to_o && wdt_clr_o));

  assert_resume_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  assert_vector_qual_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> (resume_o && gie_i));

  assert_wdt_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !ext_rst_i && wdt_ev) |=> (wdt_rst_o && !to_o && pd_o));

  assert_ext_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (clk_en_o && to_o && !resume_o && !wdt_rst_o));
endmodule

bind swc_ctrl swc_checker #(.NUM_IRQ(NUM_IRQ)) i_swc_checker (.*);

// File: tb/test_swc_ctrl.sv
module test_swc_ctrl;
  localparam int NIRQ = 4;
  localparam int SU   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_rst = 0, sleep_req = 0, gie = 0, wdt_en = 0, wdt_to = 0;
  logic [NIRQ-1:0] int_en = '0, int_flag = '0;
  logic clk_en, wdt_clr, wdt_rst, pd, to, resume, vec;

  always #5 clk = ~clk;

  swc_ctrl #(.NUM_IRQ(NIRQ), .STARTUP_CYCLES(SU)) i_swc_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_i(ext_rst), .sleep_req_i(sleep_req),
    .gie_i(gie), .int_en_i(int_en), .int_flag_i(int_flag), .wdt_en_i(wdt_en),
    .wdt_timeout_i(wdt_to), .clk_en_o(clk_en), .wdt_clr_o(wdt_clr),
    .wdt_rst_o(wdt_rst), .pd_o(pd), .to_o(to), .resume_o(resume), .vector_o(vec)
  );

  // behavioural reference: 0 run, 1 asleep, 2 starting, 3 resume
  int m, cnt;
  bit m_pd, m_to, m_clr, m_rst, m_ic;
  int n_chk = 0, n_err = 0;
  string req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m = 0; cnt = 0; m_pd = 1; m_to = 1; m_clr = 0; m_rst = 0; m_ic = 0;
    end else begin
      bit p, w;
      p = |(int_en & int_flag);
      w = wdt_en && wdt_to;
      m_clr = 0; m_rst = 0;
      if (ext_rst) begin
        m = 0; m_to = 1; m_ic = 0; cnt = 0;
      end else begin
        case (m)
          0: if (w) begin m_rst = 1; m_to = 0; m_pd = 1; end
             else if (sleep_req) begin
               m_clr = 1; m_pd = 0; m_to = 1;
               if (p) begin m = 3; m_ic = 1; end else m = 1;
             end
          1: if (p || w) begin
               m_clr = 1; if (w) m_to = 0; m_ic = p; cnt = 0; m = 2;
             end
          2: begin cnt++; if (cnt == SU) m = 3; end
          default: begin m = 0; m_ic = 0; end
        endcase
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(clk_en, (m == 0 || m == 3), "clk_en_o");
    chk(resume, (m == 3), "resume_o");
    chk(vec, (m == 3) && m_ic && gie, "vector_o");
    chk(wdt_clr, m_clr, "wdt_clr_o");
    chk(wdt_rst, m_rst, "wdt_rst_o");
    chk(pd, m_pd, "pd_o");
    chk(to, m_to, "to_o");
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic do_sleep();
    sleep_req = 1; step(); sleep_req = 0;
  endtask

  initial begin : watchdog
    #(1_500_000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    req = "R1"; step(3); rst_n = 1; step(3);
    // R10: flags while running do nothing
    req = "R10"; int_en = 4'b0011; int_flag = 4'b0011; gie = 1; step(4);
    int_flag = '0; int_en = '0; gie = 0;
    // R2 then R3: unenabled flag ignored, enabled one wakes with gie=0
    req = "R2"; do_sleep(); step(3);
    req = "R3"; int_flag = 4'b0100; step(5);
    int_en = 4'b0100; step();
    req = "R5"; int_flag = '0; int_en = '0; step(SU + 3);
    // R6: interrupt wake with gie=1 vectors
    req = "R6"; do_sleep(); step(2);
    int_en = 4'b1000; int_flag = 4'b1000; step(); int_flag = '0; int_en = '0;
    gie = 1; step(SU + 3); gie = 0;
    // R4: disabled watchdog ignored, enabled wakes and clears to
    req = "R4"; do_sleep(); wdt_to = 1; step(4);
    wdt_en = 1; step(); wdt_to = 0; gie = 1;
    req = "R6"; step(SU + 3); gie = 0;
    // R7: pending enabled interrupt at sleep request
    req = "R7"; int_en = 4'b0001; int_flag = 4'b0001; gie = 1; do_sleep();
    step(3); int_flag = '0; int_en = '0; gie = 0;
    // R8: enabled and disabled watchdog timeout while running
    req = "R8"; wdt_to = 1; step(); wdt_to = 0; step(3);
    wdt_en = 0; wdt_to = 1; step(3); wdt_to = 0; wdt_en = 1;
    // R9: external reset while asleep and during start-up
    req = "R9"; do_sleep(); step(2); ext_rst = 1; step(); ext_rst = 0; step(3);
    do_sleep(); int_en = 4'b0010; int_flag = 4'b0010; step(); int_flag = '0;
    int_en = '0; step(SU / 2); ext_rst = 1; step(); ext_rst = 0; step(SU + 3);
    ext_rst = 1; sleep_req = 1; step(); ext_rst = 0; sleep_req = 0; step(3);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule